// File: doc/BRIEF.md
# Entropy Conditioning CRC Core

This block turns three raw single-bit entropy streams into a 64-bit conditioned random word. Each stream passes through its own enable gate. The gated bits are reduced by XOR to one bit per clock, and that bit is shifted into a 64-bit conditioning register. The register works in one of two modes. In the first it is a Galois-style CRC with a fixed 64-bit polynomial. In the second it is a plain shift register with no feedback.

A control word sets the source enables, the mode and a minimum spacing between reads. It also holds three analog-side fields that this core only stores and drives out: the oscillator voltage bypass, the oscillator rate and the analog mux select. The control word is written through a single-cycle write port.

Software takes the conditioned word over a valid/ready read port. In CRC mode an interlock keeps the port not-ready for a programmed number of cycles after each completed read, so that enough fresh bits have gone into the register before the next word is taken. The normal setting is a wait of 2048 cycles.

Top module: `entropy_crc_core`

## Requirements
- R1: A synchronous active-high reset clears the control word, the conditioning register, the read data and the interlock counter. After reset rd_data is 0, all three exported analog fields are 0, and rd_ready is 1.
- R2: Control bits 0, 1 and 2 enable raw sources 0, 1 and 2 in that order. A disabled source contributes 0 to the combined bit, whatever its input does.
- R3: Each clock, the combined bit is the XOR of the enabled raw source bits, and it is shifted into bit 0 of the conditioning register.
- R4: When control bit 3 is 1, the register advances as next = (state << 1) ^ {63'b0, bit} ^ (state[63] ? 64'h231DCEE91262B8A3 : 0).
- R5: When control bit 3 is 0, the register advances as next = {state[62:0], bit}, with no polynomial feedback.
- R6: Control bits 24:9 hold a wait count W. In CRC mode, rd_ready is low for exactly W cycles after each completed read, and W = 0 gives no stall.
- R7: In shift mode (bit 3 = 0), rd_ready is always 1, whatever the wait field holds.
- R8: A read completes on a clock edge where rd_valid and rd_ready are both 1. From the next cycle, rd_data holds the register value as it stood just before that edge. At any other time rd_data holds its value.
- R9: Control bit 8 drives vco_bypass, bits 7:6 drive vco_rate and bits 5:4 drive amux_sel. Each field is exported unchanged and changes only on a control write.
- R10: A control write on one edge takes effect on the exported fields, the gating, the mode and the interlock from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bits | input | 3 | Raw entropy source bits, one per source |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 25 | Control word write data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted when high together with rd_valid |
| rd_data | output | 64 | Conditioned word from the last completed read |
| vco_bypass | output | 1 | Stored oscillator voltage bypass bit |
| vco_rate | output | 2 | Stored oscillator rate field |
| amux_sel | output | 2 | Stored analog mux select field |

## Verification
Several properties are checked on every cycle. The step rule of the register in each mode is checked against the mixer's bit. The combined bit must be zero when no source is enabled. rd_ready must stay high in shift mode and must drop after a read in CRC mode when the wait is nonzero. rd_data and the exported fields must hold between reads and between writes. Some behaviours only the bench scenarios can show. These are the exact length of the stall, including the 2048-cycle normal wait, and a hand-computed CRC step from an all-ones register. They also include whole 64-bit words that match the requirements after long runs of constant, gated and pseudo-random source patterns.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int NUM_SRC    = 3;
  localparam int WAIT_W     = 16;
  localparam int CTL_W      = NUM_SRC + 1 + 2 + 2 + 1 + WAIT_W;
  localparam int DATA_W     = 64;
  localparam logic [DATA_W-1:0] CRC_POLY = 64'h231DCEE91262B8A3;

  // Field order matters: the packed layout is the control word bit map.
  typedef struct packed {
    logic [WAIT_W-1:0]  wait_cycles;  // 24:9
    logic               bypass;       // 8
    logic [1:0]         vrate;        // 7:6
    logic [1:0]         amux;         // 5:4
    logic               crc_mode;     // 3
    logic [NUM_SRC-1:0] src_en;       // 2:0
  } ctl_t;
endpackage

// File: rtl/ecc_ctl_reg.sv
module ecc_ctl_reg
  import ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= ctl_t'(wdata);
    end
  end
endmodule

// File: rtl/ecc_src_mix.sv
module ecc_src_mix #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] en,
  output logic             mix_bit
);
  logic [N_SRC-1:0] gated;

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = raw[g] & en[g];
  end

  assign mix_bit = ^gated;
endmodule

// File: rtl/ecc_cond_reg.sv
module ecc_cond_reg #(
  parameter int                W    = 64,
  parameter logic [W-1:0]      POLY = 64'h231DCEE91262B8A3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         crc_mode,
  input  logic         in_bit,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = crc_mode & state[W-1];

  assign nxt[0] = in_bit ^ (POLY[0] & fb);
  for (genvar i = 1; i < W; i++) begin : g_tap
    if (POLY[i]) begin : g_fb
      assign nxt[i] = state[i-1] ^ fb;
    end else begin : g_plain
      assign nxt[i] = state[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else begin
      state <= nxt;
    end
  end
endmodule

// File: rtl/ecc_interlock.sv
module ecc_interlock #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          crc_mode,
  input  logic [CW-1:0] wait_cycles,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign rd_ready = !crc_mode || (cnt == '0);
  assign fire     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= wait_cycles;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/entropy_crc_core.sv
module entropy_crc_core
  import ecc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  raw_bits,
  input  logic                cfg_we,
  input  logic [CTL_W-1:0]    cfg_wdata,
  input  logic                rd_valid,
  output logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                vco_bypass,
  output logic [1:0]          vco_rate,
  output logic [1:0]          amux_sel
);
  ctl_t              ctl_q;
  logic              mix_bit;
  logic [DATA_W-1:0] state_q;
  logic              rd_fire;

  ecc_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctl_q (ctl_q)
  );

  ecc_src_mix #(.N_SRC(NUM_SRC)) u_mix (
    .raw     (raw_bits),
    .en      (ctl_q.src_en),
    .mix_bit (mix_bit)
  );

  ecc_cond_reg #(.W(DATA_W), .POLY(CRC_POLY)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .crc_mode (ctl_q.crc_mode),
    .in_bit   (mix_bit),
    .state    (state_q)
  );

  ecc_interlock #(.CW(WAIT_W)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .crc_mode    (ctl_q.crc_mode),
    .wait_cycles (ctl_q.wait_cycles),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .fire        (rd_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_fire) begin
      rd_data <= state_q;
    end
  end

  assign vco_bypass = ctl_q.bypass;
  assign vco_rate   = ctl_q.vrate;
  assign amux_sel   = ctl_q.amux;
endmodule

// File: rtl/entropy_crc_checker.sv
module entropy_crc_checker
  import ecc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] state_q,
  input logic              mix_bit,
  input ctl_t              ctl_q,
  input logic              vco_bypass,
  input logic [1:0]        vco_rate,
  input logic [1:0]        amux_sel
);
  assert_ready_shift_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.crc_mode |-> rd_ready);

  assert_stall_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && ctl_q.crc_mode && (ctl_q.wait_cycles != '0) && !cfg_we)
    |=> !rd_ready);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_ready) |=> $stable(rd_data));

  assert_shift_step_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.crc_mode |=> state_q == {$past(state_q[DATA_W-2:0]), $past(mix_bit)});

  assert_crc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.crc_mode && state_q[DATA_W-1])
    |=> state_q == ({$past(state_q[DATA_W-2:0]), $past(mix_bit)} ^ CRC_POLY));

  assert_gated_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.src_en == '0) |-> !mix_bit);

  assert_export_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable({vco_bypass, vco_rate, amux_sel}));
endmodule

bind entropy_crc_core entropy_crc_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .state_q    (state_q),
  .mix_bit    (mix_bit),
  .ctl_q      (ctl_q),
  .vco_bypass (vco_bypass),
  .vco_rate   (vco_rate),
  .amux_sel   (amux_sel)
);

// File: tb/entropy_crc_core_tb.sv
`timescale 1ns/1ps
module entropy_crc_core_tb_top;
  localparam logic [63:0] POLY = 64'h231DCEE91262B8A3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  raw_bits;
  logic        cfg_we = 1'b0;
  logic [24:0] cfg_wdata = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data;
  logic        vco_bypass;
  logic [1:0]  vco_rate;
  logic [1:0]  amux_sel;

  int checks = 0;
  int errors = 0;

  logic        auto_raw = 1'b0;
  logic [2:0]  man_raw  = 3'b000;
  logic [15:0] prng     = 16'hACE1;
  logic        hs       = 1'b0;

  logic [63:0] m_state, m_rd;
  logic [24:0] m_ctl;

  always #5 clk = ~clk;

  assign raw_bits = auto_raw ? prng[2:0] : man_raw;

  always @(negedge clk) prng <= {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};

  entropy_crc_core dut_i (
    .clk(clk), .rst(rst), .raw_bits(raw_bits), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .vco_bypass(vco_bypass), .vco_rate(vco_rate),
    .amux_sel(amux_sel)
  );

  // Reference model built from R2..R5, R8, R10
  always @(posedge clk) begin
    logic b;
    if (rst) begin
      m_state = '0; m_rd = '0; m_ctl = '0;
    end else begin
      if (hs) m_rd = m_state;
      b = ^(raw_bits & m_ctl[2:0]);
      if (m_ctl[3]) m_state = {m_state[62:0], b} ^ (m_state[63] ? POLY : 64'h0);
      else          m_state = {m_state[62:0], b};
      if (cfg_we) m_ctl = cfg_wdata;
    end
  end

  function automatic logic [24:0] mk(input logic [2:0] en, input logic mode,
                                     input logic [15:0] w, input logic [1:0] mux,
                                     input logic [1:0] rate, input logic byp);
    return {w, byp, rate, mux, mode, en};
  endfunction

  task automatic check64(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [24:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input string tag);
    logic [63:0] exp;
    int guard;
    guard = 0;
    rd_valid = 1'b1;
    while (!rd_ready && guard < 5000) begin
      @(negedge clk); guard++;
    end
    hs = 1'b1;
    @(posedge clk); #1 exp = m_rd;
    @(negedge clk);
    rd_valid = 1'b0; hs = 1'b0;
    check64(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_reset;
    check64(rd_data == 64'h0, "R1 rd_data after reset", rd_data, 64'h0);
    check64({vco_bypass, vco_rate, amux_sel} == 5'b0, "R1 exported fields after reset",
            {59'b0, vco_bypass, vco_rate, amux_sel}, 64'h0);
    check64(rd_ready == 1'b1, "R1 rd_ready after reset", {63'b0, rd_ready}, 64'h1);
  endtask

  task automatic t_export;
    cfg_wdata = mk(3'b000, 1'b0, 16'h1234, 2'd3, 2'd2, 1'b1); cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    check64({vco_bypass, vco_rate, amux_sel} == 5'b1_10_11, "R9 R10 fields one cycle after write",
            {59'b0, vco_bypass, vco_rate, amux_sel}, 64'b1_10_11);
    idle(3);
    check64({vco_bypass, vco_rate, amux_sel} == 5'b1_10_11, "R9 fields held without write",
            {59'b0, vco_bypass, vco_rate, amux_sel}, 64'b1_10_11);
    check64(rd_ready == 1'b1, "R7 ready in shift mode with wait field set",
            {63'b0, rd_ready}, 64'h1);
  endtask

  task automatic t_gating;
    auto_raw = 1'b0;
    man_raw = 3'b111; write_ctl(mk(3'b000, 1'b0, 16'd0, 2'd0, 2'd0, 1'b0));
    idle(70); do_read("R2 all sources disabled gives zero word");
    man_raw = 3'b101; write_ctl(mk(3'b010, 1'b0, 16'd0, 2'd0, 2'd0, 1'b0));
    idle(70); do_read("R2 only source1 enabled while it is low");
    check64(rd_data == 64'h0, "R2 disabled sources ignored", rd_data, 64'h0);
    man_raw = 3'b010; idle(70); do_read("R2 only source1 enabled while it is high");
    check64(rd_data == '1, "R2 source1 alone fills ones", rd_data, '1);
  endtask

  task automatic t_xor;
    auto_raw = 1'b0;
    man_raw = 3'b111; write_ctl(mk(3'b111, 1'b0, 16'd0, 2'd0, 2'd0, 1'b0));
    idle(70); do_read("R3 model compare three ones");
    check64(rd_data == '1, "R3 xor of three ones is one", rd_data, '1);
    man_raw = 3'b011; idle(70); do_read("R3 model compare two ones");
    check64(rd_data == 64'h0, "R3 xor of two ones is zero", rd_data, 64'h0);
  endtask

  task automatic t_shift_random;
    auto_raw = 1'b1;
    write_ctl(mk(3'b111, 1'b0, 16'd9, 2'd0, 2'd0, 1'b0));
    idle(70); do_read("R5 shift mode random word");
    do_read("R7 R8 back-to-back read in shift mode");
    idle(13); do_read("R5 shift mode second word");
  endtask

  task automatic t_crc_known;
    auto_raw = 1'b0; man_raw = 3'b001;
    write_ctl(mk(3'b001, 1'b0, 16'd0, 2'd0, 2'd0, 1'b0));
    idle(70);
    // register is now all ones; switch to CRC with no sources
    cfg_wdata = mk(3'b000, 1'b1, 16'd0, 2'd0, 2'd0, 1'b0); cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
    do_read("R4 model compare one CRC step");
    check64(rd_data == 64'hDCE23116ED9D475D, "R4 one CRC step from all ones",
            rd_data, 64'hDCE23116ED9D475D);
  endtask

  task automatic t_crc_random;
    auto_raw = 1'b1;
    write_ctl(mk(3'b111, 1'b1, 16'd0, 2'd0, 2'd0, 1'b0));
    idle(100); do_read("R4 CRC mode random word");
    do_read("R6 zero wait allows back-to-back read");
    idle(31); do_read("R4 CRC mode third word");
  endtask

  task automatic measure_stall(input logic [15:0] w, input string tag);
    int low;
    logic [63:0] held;
    write_ctl(mk(3'b111, 1'b1, w, 2'd0, 2'd0, 1'b0));
    do_read("R8 read that arms interlock");
    held = rd_data;
    low = 0;
    rd_valid = 1'b1;
    while (!rd_ready && low < 5000) begin
      @(negedge clk); low++;
    end
    rd_valid = 1'b0;
    check64(rd_data == held, "R8 no capture while stalled", rd_data, held);
    check64(low == int'(w), tag, 64'(low), 64'(w));
  endtask

  task automatic t_interlock;
    auto_raw = 1'b1;
    measure_stall(16'd5, "R6 stall length for wait 5");
    measure_stall(16'd1, "R6 stall length for wait 1");
    measure_stall(16'd2048, "R6 stall length for normal wait 2048");
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_export();
    t_gating();
    t_xor();
    t_shift_random();
    t_crc_known();
    t_crc_random();
    t_interlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule